// File: doc/BRIEF.md
# Masked Privileged Control Register File

This block holds a processor's privileged 64-bit control registers and gives access to them by a 6-bit index. Each register has its own write rule. Some keep only certain bit fields. Some are cleared by any write. Some can only be read, and some can only be written. A few registers are not storage at all: a write to them issues a flush request to the address translation buffers. The cycle-count register is a special case: its upper half is stored and its lower half comes from a live counter input.

There is one combinational read port and one write port that takes effect at the clock edge. Each port reports an illegal access on a fault output in the same cycle as the access. A write can be marked speculative. Such a write is discarded completely: it changes no state, raises no fault and issues no flush request.

Top module: `ctl_regfile`

## Requirements
- R1: The index map is as follows. Scratch registers are at 0..15. The other registers are: 32 vector base, 33 exception PC, 34 async-trap request, 35 async-trap enable, 36 current mode, 37 alternate mode (write-only), 38 software interrupt request, 39 instruction ASN, 40 data ASN, 41 and 42 page-table bases, 43 data-cache mode, 44 miss-address mode, 45 instruction control, 46 exception summary, 47 exception mask, 48 memory control, 49 cycle count, 50..53 read-only status, 54 flush-all, 55 flush-process, 56 flush-single (54..56 are write-only), and 57 priority level. Any other index faults on both read and write, and changes nothing.
- R2: After reset, every register reads 0, except memory control, which reads 0x6, and vector base, which reads the BASE_VEC parameter.
- R3: Scratch registers, vector base, memory control and cycle count store the whole 64-bit value written.
- R4: The following write masks apply. Async request and async enable keep 0xf. Current mode and alternate mode keep 0x18. Software request keeps 0x7fff0. Instruction ASN keeps 0x7f0. Data ASN keeps bits 63:57. Both page-table bases keep bits 63:30. Data-cache mode and miss-address mode keep 0x3f. Instruction control keeps 0xffffff0300. Priority level keeps 0x1f.
- R5: A write to the exception PC stores the value with bit 1 forced to 0.
- R6: Any write to exception summary or exception mask leaves that register at 0.
- R7: A non-speculative write to an index in 50..53 raises wr_fault in the same cycle and leaves the register unchanged.
- R8: A read of a write-only index (37, 54, 55, 56) raises rd_fault and returns rd_data = 0.
- R9: A read of index 49 returns the stored bits 63:32 together with cyc_cnt[31:0] of the same cycle.
- R10: A write to index 54 or 55 raises flush_all or flush_proc, respectively, for exactly the one cycle after the write edge. At most one flush output is high at any time.
- R11: A write to index 56 raises flush_addr for one cycle after the write edge. In that cycle, flush_va equals the written value and flush_asn equals data-ASN bits 63:57.
- R12: A write with wr_spec high changes no register, raises no fault and issues no flush.
- R13: A read to the same index as a write in the same cycle returns the value from before the write. The new value appears after the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_en | input | 1 | Read request |
| rd_idx | input | IDX_W | Read index |
| rd_data | output | 64 | Read data, 0 on fault or idle |
| rd_fault | output | 1 | Illegal read, same cycle |
| wr_en | input | 1 | Write request |
| wr_spec | input | 1 | Write is speculative; discard it |
| wr_idx | input | IDX_W | Write index |
| wr_data | input | 64 | Write data |
| wr_fault | output | 1 | Illegal write, same cycle |
| cyc_cnt | input | 64 | Live cycle counter |
| flush_all | output | 1 | Flush-all request pulse |
| flush_proc | output | 1 | Flush-process request pulse |
| flush_addr | output | 1 | Flush-single-address request pulse |
| flush_va | output | 64 | Address for flush_addr |
| flush_asn | output | 7 | Address-space number for flush_addr |

## Verification
A read and a write can target the same register in the same cycle. The bench provokes this by driving both ports at one index. It checks that the read data sampled before the edge still holds the old value, and that a read after the edge returns the masked new value. The cycle-count read is judged the same way: a stored upper half is combined with counter bits that the bench changes independently.

// File: rtl/ctl_regfile.sv
module ctl_regfile #(
  parameter int          IDX_W    = 6,
  parameter int          NSCRATCH = 16,
  parameter logic [63:0] BASE_VEC = 64'h0000_0000_0001_0000,
  parameter logic [63:0] MCTL_RST = 64'h6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [63:0]      rd_data,
  output logic             rd_fault,
  input  logic             wr_en,
  input  logic             wr_spec,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [63:0]      wr_data,
  output logic             wr_fault,
  input  logic [63:0]      cyc_cnt,
  output logic             flush_all,
  output logic             flush_proc,
  output logic             flush_addr,
  output logic [63:0]      flush_va,
  output logic [6:0]       flush_asn
);
  localparam int NREG = 1 << IDX_W;
  localparam logic [IDX_W-1:0] X_VBASE = IDX_W'(32);
  localparam logic [IDX_W-1:0] X_EPC   = IDX_W'(33);
  localparam logic [IDX_W-1:0] X_AREQ  = IDX_W'(34);
  localparam logic [IDX_W-1:0] X_AEN   = IDX_W'(35);
  localparam logic [IDX_W-1:0] X_CMODE = IDX_W'(36);
  localparam logic [IDX_W-1:0] X_AMODE = IDX_W'(37);
  localparam logic [IDX_W-1:0] X_SWREQ = IDX_W'(38);
  localparam logic [IDX_W-1:0] X_IASN  = IDX_W'(39);
  localparam logic [IDX_W-1:0] X_DASN  = IDX_W'(40);
  localparam logic [IDX_W-1:0] X_IPTB  = IDX_W'(41);
  localparam logic [IDX_W-1:0] X_DPTB  = IDX_W'(42);
  localparam logic [IDX_W-1:0] X_DCM   = IDX_W'(43);
  localparam logic [IDX_W-1:0] X_MAM   = IDX_W'(44);
  localparam logic [IDX_W-1:0] X_ICTL  = IDX_W'(45);
  localparam logic [IDX_W-1:0] X_ESUM  = IDX_W'(46);
  localparam logic [IDX_W-1:0] X_EMSK  = IDX_W'(47);
  localparam logic [IDX_W-1:0] X_MCTL  = IDX_W'(48);
  localparam logic [IDX_W-1:0] X_CYC   = IDX_W'(49);
  localparam logic [IDX_W-1:0] X_RO0   = IDX_W'(50);
  localparam logic [IDX_W-1:0] X_RO3   = IDX_W'(53);
  localparam logic [IDX_W-1:0] X_FALL  = IDX_W'(54);
  localparam logic [IDX_W-1:0] X_FPROC = IDX_W'(55);
  localparam logic [IDX_W-1:0] X_FONE  = IDX_W'(56);
  localparam logic [IDX_W-1:0] X_IPL   = IDX_W'(57);

  typedef enum logic [1:0] {K_NONE, K_RW, K_RO, K_WO} kind_t;

  function automatic kind_t kind_of(input logic [IDX_W-1:0] x);
    if (int'(x) < NSCRATCH) return K_RW;
    if (x == X_AMODE || x == X_FALL || x == X_FPROC || x == X_FONE) return K_WO;
    if (x >= X_RO0 && x <= X_RO3) return K_RO;
    if ((x >= X_VBASE && x <= X_CYC) || x == X_IPL) return K_RW;
    return K_NONE;
  endfunction

  function automatic logic [63:0] masked(input logic [IDX_W-1:0] x, input logic [63:0] d);
    case (x)
      X_EPC:                   return d & ~64'h2;
      X_AREQ, X_AEN:           return d & 64'hf;
      X_CMODE, X_AMODE:        return d & 64'h18;
      X_SWREQ:                 return d & 64'h7fff0;
      X_IASN:                  return d & 64'h7f0;
      X_DASN:                  return {d[63:57], 57'b0};
      X_IPTB, X_DPTB:          return {d[63:30], 30'b0};
      X_DCM, X_MAM:            return d & 64'h3f;
      X_ICTL:                  return d & 64'hff_ffff_0300;
      X_IPL:                   return d & 64'h1f;
      X_ESUM, X_EMSK,
      X_FALL, X_FPROC:         return 64'b0;
      default:                 return d;
    endcase
  endfunction

  logic [63:0] regs [NREG];
  kind_t rk, wk;
  logic  wr_go, commit;

  assign rk       = kind_of(rd_idx);
  assign wk       = kind_of(wr_idx);
  assign wr_go    = wr_en && !wr_spec;
  assign wr_fault = wr_go && (wk == K_NONE || wk == K_RO);
  assign commit   = wr_go && !wr_fault;
  assign rd_fault = rd_en && (rk == K_NONE || rk == K_WO);
  assign rd_data  = (!rd_en || rd_fault) ? 64'b0 :
                    (rd_idx == X_CYC) ? {regs[X_CYC][63:32], cyc_cnt[31:0]} :
                    regs[rd_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= 64'b0;
      regs[X_VBASE] <= BASE_VEC;
      regs[X_MCTL]  <= MCTL_RST;
      flush_all  <= 1'b0;
      flush_proc <= 1'b0;
      flush_addr <= 1'b0;
      flush_va   <= 64'b0;
      flush_asn  <= 7'b0;
    end else begin
      if (commit) regs[wr_idx] <= masked(wr_idx, wr_data);
      flush_all  <= commit && wr_idx == X_FALL;
      flush_proc <= commit && wr_idx == X_FPROC;
      flush_addr <= commit && wr_idx == X_FONE;
      if (commit && wr_idx == X_FONE) begin
        flush_va  <= wr_data;
        flush_asn <= regs[X_DASN][63:57];
      end
    end
  end
endmodule

module ctl_regfile_chk #(
  parameter int IDX_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rd_en,
  input logic [IDX_W-1:0] rd_idx,
  input logic [63:0]      rd_data,
  input logic             rd_fault,
  input logic             wr_en,
  input logic             wr_spec,
  input logic [IDX_W-1:0] wr_idx,
  input logic [63:0]      wr_data,
  input logic             wr_fault,
  input logic [63:0]      cyc_cnt,
  input logic             flush_all,
  input logic             flush_proc,
  input logic             flush_addr,
  input logic [63:0]      flush_va,
  input logic [6:0]       flush_asn
);
  localparam logic [IDX_W-1:0] C_EPC  = IDX_W'(33);
  localparam logic [IDX_W-1:0] C_AMOD = IDX_W'(37);
  localparam logic [IDX_W-1:0] C_CYC  = IDX_W'(49);
  localparam logic [IDX_W-1:0] C_RO0  = IDX_W'(50);
  localparam logic [IDX_W-1:0] C_RO3  = IDX_W'(53);
  localparam logic [IDX_W-1:0] C_FALL = IDX_W'(54);
  localparam logic [IDX_W-1:0] C_FPRC = IDX_W'(55);
  localparam logic [IDX_W-1:0] C_FONE = IDX_W'(56);

  a_r12_spec_nofault: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_spec |-> !wr_fault);
  a_r12_spec_noflush: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_spec |=> !(flush_all || flush_proc || flush_addr));
  a_r10_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({flush_all, flush_proc, flush_addr}));
  a_r10_all_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !wr_spec && wr_idx == C_FALL |=> flush_all);
  a_r10_proc_src: assert property (@(posedge clk) disable iff (!rst_n)
    flush_proc |-> $past(wr_en && !wr_spec && wr_idx == C_FPRC));
  a_r11_va: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !wr_spec && wr_idx == C_FONE |=> flush_addr && flush_va == $past(wr_data));
  a_r8_wo_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && (rd_idx == C_AMOD || (rd_idx >= C_FALL && rd_idx <= C_FONE)) |-> rd_fault && rd_data == 64'b0);
  a_r7_ro_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !wr_spec && wr_idx >= C_RO0 && wr_idx <= C_RO3 |-> wr_fault);
  a_r9_cyc_low: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && rd_idx == C_CYC |-> rd_data[31:0] == cyc_cnt[31:0]);
  a_r5_epc_bit1: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && rd_idx == C_EPC |-> !rd_data[1]);
endmodule

bind ctl_regfile ctl_regfile_chk #(.IDX_W(IDX_W)) u_chk (.*);

// File: tb/ctl_regfile_bench.sv
module ctl_regfile_bench;
  localparam logic [63:0] BASE = 64'h0000_0000_0001_0000;
  logic clk = 0, rst_n = 0;
  logic rd_en = 0, wr_en = 0, wr_spec = 0;
  logic [5:0] rd_idx = 0, wr_idx = 0;
  logic [63:0] wr_data = 0, cyc_cnt = 0, rd_data, flush_va;
  logic rd_fault, wr_fault, flush_all, flush_proc, flush_addr;
  logic [6:0] flush_asn;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  ctl_regfile #(.BASE_VEC(BASE)) u_ctl_regfile (.*);

  localparam int NV = 17;
  localparam logic [5:0] V_IDX [NV] = '{6'd3, 6'd32, 6'd33, 6'd34, 6'd35, 6'd36, 6'd38, 6'd39,
    6'd40, 6'd41, 6'd42, 6'd43, 6'd44, 6'd45, 6'd57, 6'd48, 6'd15};
  localparam logic [63:0] V_W [NV] = '{64'hFFFF_FFFF_FFFF_FFFF, 64'h1234_5678_9ABC_DEF0,
    64'hFFFF_FFFF_FFFF_FFFF, 64'hFF, 64'h1235, 64'hFF, 64'hFFFF_FFFF_FFFF_FFFF,
    64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF,
    64'h1_7FFF_FFFF, 64'hFF, 64'h41, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFF, 64'hAB, 64'h5A5A};
  localparam logic [63:0] V_E [NV] = '{64'hFFFF_FFFF_FFFF_FFFF, 64'h1234_5678_9ABC_DEF0,
    64'hFFFF_FFFF_FFFF_FFFD, 64'hF, 64'h5, 64'h18, 64'h7FFF0, 64'h7F0,
    64'hFE00_0000_0000_0000, 64'hFFFF_FFFF_C000_0000, 64'h1_4000_0000, 64'h3F, 64'h1,
    64'hFF_FFFF_0300, 64'h1F, 64'hAB, 64'h5A5A};

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] x, input logic [63:0] d, input logic spec, output logic f);
    @(negedge clk);
    wr_en = 1; wr_spec = spec; wr_idx = x; wr_data = d;
    #1 f = wr_fault;
    @(posedge clk); #1;
    wr_en = 0; wr_spec = 0;
  endtask

  task automatic rd(input logic [5:0] x, output logic [63:0] d, output logic f);
    @(negedge clk);
    rd_en = 1; rd_idx = x;
    #1 d = rd_data; f = rd_fault;
    rd_en = 0;
  endtask

  task automatic flushes(output logic [2:0] fl);
    @(negedge clk); #1 fl = {flush_all, flush_proc, flush_addr};
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [63:0] d;
    logic f;
    logic [2:0] fl;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;

    rd(6'd48, d, f); chk("R2 memctl reset", d, 64'h6);
    rd(6'd32, d, f); chk("R2 vbase reset", d, BASE);
    rd(6'd3, d, f);  chk("R2 scratch reset", d, 64'h0);
    chk("R2 outputs idle", {61'b0, flush_all, flush_proc, flush_addr}, 64'h0);

    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = (V_IDX[i] == 6'd33) ? "R5" :
            (V_IDX[i] < 6'd16 || V_IDX[i] == 6'd32 || V_IDX[i] == 6'd48) ? "R3" : "R4";
      wr(V_IDX[i], V_W[i], 1'b0, f);
      chk({tag, " write fault"}, {63'b0, f}, 64'h0);
      rd(V_IDX[i], d, f);
      chk({tag, " readback"}, d, V_E[i]);
    end

    wr(6'd46, 64'hFFFF, 1'b0, f); rd(6'd46, d, f); chk("R6 summary cleared", d, 64'h0);
    wr(6'd47, 64'h1, 1'b0, f);    rd(6'd47, d, f); chk("R6 mask cleared", d, 64'h0);

    wr(6'd50, 64'h77, 1'b0, f); chk("R7 ro write fault", {63'b0, f}, 64'h1);
    rd(6'd50, d, f); chk("R7 ro unchanged", d, 64'h0); chk("R7 ro readable", {63'b0, f}, 64'h0);

    wr(6'd60, 64'h9, 1'b0, f); chk("R1 unknown write fault", {63'b0, f}, 64'h1);
    rd(6'd60, d, f); chk("R1 unknown read fault", {63'b0, f}, 64'h1); chk("R1 unknown data", d, 64'h0);

    rd(6'd54, d, f); chk("R8 wo read fault", {63'b0, f}, 64'h1); chk("R8 wo data", d, 64'h0);
    rd(6'd37, d, f); chk("R8 alt mode read fault", {63'b0, f}, 64'h1);

    wr(6'd49, 64'hDEAD_BEEF_1111_2222, 1'b0, f);
    cyc_cnt = 64'h0000_0007_CAFE_0001;
    rd(6'd49, d, f); chk("R9 cycle merge", d, 64'hDEAD_BEEF_CAFE_0001);
    cyc_cnt = 64'h0000_0009_0000_0042;
    rd(6'd49, d, f); chk("R9 cycle live", d, 64'hDEAD_BEEF_0000_0042);

    wr(6'd54, 64'h5, 1'b0, f); flushes(fl); chk("R10 flush all", {61'b0, fl}, 64'h4);
    flushes(fl); chk("R10 flush all one cycle", {61'b0, fl}, 64'h0);
    wr(6'd55, 64'h5, 1'b0, f); flushes(fl); chk("R10 flush proc", {61'b0, fl}, 64'h2);

    wr(6'd40, 64'hAA00_0000_0000_0000, 1'b0, f);
    wr(6'd56, 64'h1234, 1'b0, f); flushes(fl);
    chk("R11 flush addr", {61'b0, fl}, 64'h1);
    chk("R11 flush va", flush_va, 64'h1234);
    chk("R11 flush asn", {57'b0, flush_asn}, 64'h55);

    wr(6'd5, 64'hBAD, 1'b1, f); chk("R12 spec no fault", {63'b0, f}, 64'h0);
    rd(6'd5, d, f); chk("R12 spec no write", d, 64'h0);
    wr(6'd54, 64'h0, 1'b1, f); flushes(fl); chk("R12 spec no flush", {61'b0, fl}, 64'h0);
    wr(6'd51, 64'h1, 1'b1, f); chk("R12 spec ro no fault", {63'b0, f}, 64'h0);

    wr(6'd7, 64'h11, 1'b0, f);
    @(negedge clk);
    wr_en = 1; wr_idx = 6'd7; wr_data = 64'h22; rd_en = 1; rd_idx = 6'd7;
    #1 chk("R13 read old value", rd_data, 64'h11);
    @(posedge clk); #1 wr_en = 0;
    chk("R13 new value after edge", rd_data, 64'h22);
    rd_en = 0;

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule